// File: doc/BRIEF.md
# Stereo Audio Serial Transmitter (Philips Framing)

This block turns a stream of 16-bit host words into a stereo serial audio stream using the Philips framing convention. Each channel slot is 32 bit periods long. Every sample is built from two host words, high half first: with the 32-bit data length both words are sent whole; with the 24-bit data length the second word gives only its upper byte, and the slot ends with eight zero bits. Each frame sends the left channel and then the right channel. The word-select line is low for left and high for right, and it changes one bit period ahead of each new channel's MSB.

The block makes its bit clock by dividing the system clock by `2*HALF_DIV`. A polarity input chooses whether the bit clock rests low or high. Data and word select change on the falling edge of the internal clock, and the pin is that clock XOR the polarity input. A two-word buffer raises `word_req_o` whenever it has room for another word. If a slot has to start before two words are buffered, the block pulses `underrun_o` and sends zeros for that slot.

The FSM has four states: `ST_IDLE`, `ST_LEFT`, `ST_RIGHT` and `ST_STOP`. The transitions are:
- start: `ST_IDLE`→`ST_LEFT` when enable is high. The left sample is loaded and word select is driven low.
- left_done: `ST_LEFT`→`ST_RIGHT` on the falling tick that carries the left LSB.
- right_next: `ST_RIGHT`→`ST_LEFT` on the right-LSB tick while enable is high.
- right_last: `ST_RIGHT`→`ST_STOP` on the right-LSB tick while enable is low.
- drain: `ST_STOP`→`ST_IDLE` on the next falling tick, which ends with the clock at rest.

Top module: `i2s_philips_tx`

## Requirements
- R1: With `data_len_i`=2'b10, the slot carries {first word, second word} as a 32-bit value, MSB first.
- R2: With `data_len_i`=2'b01, the slot carries bits [15:0] of the first word, then bits [15:8] of the second word, then eight zeros, MSB first. Bits [7:0] of the second word have no effect.
- R3: Each frame sends the left sample and then the right sample. Word select is 0 during the left slot and 1 during the right slot.
- R4: Word select changes at the same falling edge that puts out the LSB of the previous slot, one bit period before the new slot's MSB. The first bit sent after start is 0 with word select 0.
- R5: `bck_o` equals `ckpol_i` whenever the block is idle. `ckpol_i`=0 means the clock rests low and `ckpol_i`=1 means it rests high.
- R6: `sd_o` and `ws_o` change only on falling edges of the internal clock (`bck_o` XOR `ckpol_i`). One bit period is `2*HALF_DIV` clock cycles.
- R7: `word_req_o` is 1 while fewer than two words are buffered. A write while `word_req_o` is 0 is ignored.
- R8: If a slot must be loaded while fewer than two words are buffered, `underrun_o` pulses for one cycle, the slot sends all zeros, and any single buffered word is discarded.
- R9: When enable is low at the end of a right slot, the block finishes that frame, goes idle, and stops the clock. A one-frame run gives exactly 65 rising edges of the internal clock.
- R10: After reset `word_req_o`=1, `underrun_o`=0, `sd_o`=0, `ws_o`=0, and `bck_o`=`ckpol_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Start or continue streaming frames |
| data_len_i | input | 2 | 2'b10 selects 32-bit samples, 2'b01 selects 24-bit samples |
| ckpol_i | input | 1 | Bit clock rest level |
| wr_en_i | input | 1 | Host word write strobe |
| wr_data_i | input | 16 | Host word |
| word_req_o | output | 1 | Buffer can accept a word |
| underrun_o | output | 1 | One-cycle pulse when a slot is loaded without a full sample |
| bck_o | output | 1 | Serial bit clock |
| ws_o | output | 1 | Word select (0 left, 1 right) |
| sd_o | output | 1 | Serial data |

## Verification
The assertions check on every cycle that:
- word select is low in the left state and high in the right state, and moves only on the tick that carries a slot's LSB;
- data changes only on a falling tick, and the clock rests at its polarity level when idle;
- the FSM reaches idle only through the drain state;
- a full buffer holds its contents, and a load from a short buffer raises the underrun flag.

Only the bench's scenarios can show the bit-exact sample values. These include packing both sample lengths, zero padding, and ignoring the unused low byte. The scenarios also cover dropping a partial word, ignoring writes to a full buffer, and the frame length seen by a receiver on the rising clock edges.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;
    localparam int WORD_W = 16;
    localparam int SLOT_W = 32;
    localparam int BIT_CW = $clog2(SLOT_W);
    localparam logic [1:0] DLEN_24 = 2'b01;
    localparam logic [1:0] DLEN_32 = 2'b10;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEFT,
        ST_RIGHT,
        ST_STOP
    } tx_state_e;
endpackage

// File: rtl/i2s_tx_bitclk.sv
module i2s_tx_bitclk #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic sck_o,
    output logic fall_tick_o
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] div_q;
    logic          sck_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
            sck_q <= 1'b0;
        end else if (!run_i) begin
            div_q <= '0;
            sck_q <= 1'b0;
        end else if (div_q == LAST) begin
            div_q <= '0;
            sck_q <= ~sck_q;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign sck_o       = sck_q;
    assign fall_tick_o = run_i && sck_q && (div_q == LAST);

    AST_TICK_IS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        fall_tick_o |=> !sck_q); // R6
    AST_CLK_RESTS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !sck_q); // R5
endmodule

// File: rtl/i2s_tx_word_buf.sv
module i2s_tx_word_buf
    import i2s_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        dlen_i,
    input  logic              wr_en_i,
    input  logic [WORD_W-1:0] wr_data_i,
    input  logic              pop_i,
    output logic              req_o,
    output logic [SLOT_W-1:0] sample_o,
    output logic              underrun_o
);
    logic [WORD_W-1:0] hi_q, lo_q;
    logic [1:0]        cnt_q;
    logic              full, wr_acc, und_q;

    assign full   = (cnt_q == 2'd2);
    assign req_o  = !full;
    assign wr_acc = wr_en_i && req_o;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q  <= '0;
            lo_q  <= '0;
            cnt_q <= 2'd0;
            und_q <= 1'b0;
        end else begin
            und_q <= pop_i && !full;
            if (pop_i) begin
                if (wr_acc) begin
                    hi_q  <= wr_data_i;
                    cnt_q <= 2'd1;
                end else begin
                    cnt_q <= 2'd0;
                end
            end else if (wr_acc) begin
                if (cnt_q == 2'd0) hi_q <= wr_data_i;
                else               lo_q <= wr_data_i;
                cnt_q <= cnt_q + 2'd1;
            end
        end
    end

    always_comb begin
        if (!full)
            sample_o = '0;
        else if (dlen_i == DLEN_24)
            sample_o = {hi_q, lo_q[WORD_W-1:8], 8'h00};
        else
            sample_o = {hi_q, lo_q};
    end

    assign underrun_o = und_q;

    AST_UNDERRUN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && cnt_q != 2'd2) |=> und_q); // R8
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop_i) |=> ($stable(hi_q) && $stable(lo_q) && cnt_q == 2'd2)); // R7
    AST_ROOM_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |=> req_o); // R7
endmodule

// File: rtl/i2s_tx_serializer.sv
module i2s_tx_serializer
    import i2s_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic              tick_i,
    input  logic [SLOT_W-1:0] sample_i,
    output logic              pop_o,
    output logic              run_o,
    output logic              sd_o,
    output logic              ws_o
);
    localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(SLOT_W - 1);

    tx_state_e         state_q, state_d;
    logic [BIT_CW-1:0] bit_q;
    logic [SLOT_W-1:0] sh_q;
    logic              sd_q, ws_q;
    logic              last_bit, start, slot_end;

    assign last_bit = (bit_q == LAST_BIT);
    assign start    = (state_q == ST_IDLE) && enable_i;
    assign slot_end = tick_i && last_bit &&
                      ((state_q == ST_LEFT) || (state_q == ST_RIGHT));
    assign pop_o    = start || (slot_end &&
                      ((state_q == ST_LEFT) || enable_i));
    assign run_o    = (state_q != ST_IDLE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (enable_i) state_d = ST_LEFT;
            ST_LEFT:  if (tick_i && last_bit) state_d = ST_RIGHT;
            ST_RIGHT: if (tick_i && last_bit) state_d = enable_i ? ST_LEFT : ST_STOP;
            ST_STOP:  if (tick_i) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            bit_q <= '0;
            sd_q  <= 1'b0;
            ws_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (enable_i) begin
                        sh_q  <= sample_i;
                        bit_q <= '0;
                        sd_q  <= 1'b0;
                        ws_q  <= 1'b0;
                    end
                end
                ST_LEFT, ST_RIGHT: begin
                    if (tick_i) begin
                        sd_q <= sh_q[SLOT_W-1];
                        if (last_bit) begin
                            bit_q <= '0;
                            ws_q  <= (state_q == ST_LEFT);
                            sh_q  <= pop_o ? sample_i : '0;
                        end else begin
                            bit_q <= bit_q + 1'b1;
                            sh_q  <= {sh_q[SLOT_W-2:0], 1'b0};
                        end
                    end
                end
                ST_STOP: begin
                    if (tick_i) sd_q <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    assign sd_o = sd_q;
    assign ws_o = ws_q;

    AST_WS_LOW_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LEFT) |-> !ws_q); // R3
    AST_WS_HIGH_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RIGHT) |-> ws_q); // R3
    AST_WS_AT_SLOT_END: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ws_q) |-> $past(tick_i && last_bit)); // R4
    AST_SD_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sd_q) |-> $past(tick_i)); // R6
    AST_IDLE_VIA_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && $past(state_q) != ST_IDLE) |-> $past(state_q) == ST_STOP); // R9
endmodule

// File: rtl/i2s_philips_tx.sv
module i2s_philips_tx
    import i2s_tx_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic [1:0]        data_len_i,
    input  logic              ckpol_i,
    input  logic              wr_en_i,
    input  logic [WORD_W-1:0] wr_data_i,
    output logic              word_req_o,
    output logic              underrun_o,
    output logic              bck_o,
    output logic              ws_o,
    output logic              sd_o
);
    logic              run, sck, tick, pop;
    logic [SLOT_W-1:0] sample;

    i2s_tx_bitclk #(.HALF_DIV(HALF_DIV)) u_bitclk (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (run),
        .sck_o       (sck),
        .fall_tick_o (tick)
    );

    i2s_tx_word_buf u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .dlen_i     (data_len_i),
        .wr_en_i    (wr_en_i),
        .wr_data_i  (wr_data_i),
        .pop_i      (pop),
        .req_o      (word_req_o),
        .sample_o   (sample),
        .underrun_o (underrun_o)
    );

    i2s_tx_serializer u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable_i (enable_i),
        .tick_i   (tick),
        .sample_i (sample),
        .pop_o    (pop),
        .run_o    (run),
        .sd_o     (sd_o),
        .ws_o     (ws_o)
    );

    assign bck_o = sck ^ ckpol_i;

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (bck_o == ckpol_i)); // R5
endmodule

// File: tb/test_i2s_philips_tx.sv
module test_i2s_philips_tx;
    localparam int HD = 2;

    typedef struct packed {
        logic [1:0]  dl;
        logic        pol;
        logic [15:0] lh;
        logic [15:0] ll;
        logic [15:0] rh;
        logic [15:0] rl;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{2'b10, 1'b0, 16'hA5F0, 16'h0F1E, 16'h8001, 16'h7FFE},
        '{2'b10, 1'b1, 16'hFFFF, 16'h0000, 16'h0000, 16'hFFFF},
        '{2'b01, 1'b0, 16'h1234, 16'h56AB, 16'h89AB, 16'hCDEF},
        '{2'b01, 1'b1, 16'h8000, 16'h01FF, 16'h7FFF, 16'hFE00},
        '{2'b10, 1'b0, 16'h0000, 16'h0001, 16'h8000, 16'h0000},
        '{2'b01, 1'b0, 16'hFFFF, 16'hFFFF, 16'h0000, 16'h00FF}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [1:0]  data_len = 2'b10;
    logic        ckpol = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        word_req, underrun, bck, ws, sd;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    logic rx_sd [0:127];
    logic rx_ws [0:127];
    int   rx_n = 0;
    int   und_n = 0;
    int   bad_edge = 0;
    int   bad_period = 0;
    int   last_rise = 0;
    logic prev_ick = 1'b0, prev_sd = 1'b0, prev_ws = 1'b0;

    always #2 clk = ~clk;

    i2s_philips_tx #(.HALF_DIV(HD)) i_i2s_philips_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable_i   (enable),
        .data_len_i (data_len),
        .ckpol_i    (ckpol),
        .wr_en_i    (wr_en),
        .wr_data_i  (wr_data),
        .word_req_o (word_req),
        .underrun_o (underrun),
        .bck_o      (bck),
        .ws_o       (ws),
        .sd_o       (sd)
    );

    // Receiver model: samples on the rising edge of the internal clock.
    always @(negedge clk) begin
        logic ick;
        ick = bck ^ ckpol;
        if (rst_n) begin
            if (!prev_ick && ick) begin
                if (rx_n > 0 && (cyc - last_rise) != 2 * HD) bad_period++;
                last_rise = cyc;
                if (rx_n < 128) begin
                    rx_sd[rx_n] = sd;
                    rx_ws[rx_n] = ws;
                end
                rx_n++;
            end
            if ((sd != prev_sd || ws != prev_ws) && !(prev_ick && !ick)) bad_edge++;
            if (underrun) und_n++;
        end
        prev_ick = ick;
        prev_sd  = sd;
        prev_ws  = ws;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired: actual %0d cycles expected < 150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic write_word(input logic [15:0] w);
        do @(negedge clk); while (!word_req);
        wr_en = 1'b1;
        wr_data = w;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic raw_write(input logic [15:0] w);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = w;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [31:0] exp_sample(input logic [1:0] dl, input logic [15:0] hi, input logic [15:0] lo);
        return (dl == 2'b01) ? {hi, lo[15:8], 8'h00} : {hi, lo};
    endfunction

    function automatic logic [31:0] rx_word(input int base);
        logic [31:0] v = '0;
        for (int i = 0; i < 32; i++) v = {v[30:0], rx_sd[base + i]};
        return v;
    endfunction

    task automatic clear_rx();
        @(negedge clk);
        rx_n = 0;
        und_n = 0;
    endtask

    task automatic wait_idle();
        repeat (80 * 2 * HD) @(negedge clk);
    endtask

    task automatic check_frame(input string tag, input logic [31:0] el, input logic [31:0] er, input int eu);
        int wsbad = 0;
        check(rx_n == 65, "R9 frame length", rx_n, 65);
        check(rx_sd[0] == 1'b0 && rx_ws[0] == 1'b0, "R4 lead bit", {rx_sd[0], rx_ws[0]}, 0);
        check(rx_word(1) == el, {tag, " left"}, rx_word(1), el);
        check(rx_word(33) == er, {tag, " right"}, rx_word(33), er);
        for (int i = 0; i < 65; i++)
            if (rx_ws[i] != ((i >= 32 && i <= 63) ? 1'b1 : 1'b0)) wsbad++;
        check(wsbad == 0, "R3 ws levels", wsbad, 0);
        check(rx_ws[31] == 1'b0 && rx_ws[32] == 1'b1, "R4 ws lead", {rx_ws[31], rx_ws[32]}, 2'b01);
        check(und_n == eu, "R8 underrun count", und_n, eu);
        check(bck == ckpol, "R5 rest level", bck, ckpol);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(word_req == 1'b1 && underrun == 1'b0, "R10 req/underrun", {word_req, underrun}, 2'b10);
        check(sd == 1'b0 && ws == 1'b0 && bck == 1'b0, "R10 sd/ws/bck", {sd, ws, bck}, 0);
        ckpol = 1'b1;
        @(negedge clk);
        check(bck == 1'b1, "R5 idle high", bck, 1);
        ckpol = 1'b0;

        // Vector table
        for (int v = 0; v < 6; v++) begin
            @(negedge clk);
            data_len = VECS[v].dl;
            ckpol = VECS[v].pol;
            write_word(VECS[v].lh);
            write_word(VECS[v].ll);
            clear_rx();
            enable = 1'b1;
            @(negedge clk);
            enable = 1'b0;
            write_word(VECS[v].rh);
            write_word(VECS[v].rl);
            wait_idle();
            check_frame(VECS[v].dl == 2'b01 ? "R2" : "R1",
                        exp_sample(VECS[v].dl, VECS[v].lh, VECS[v].ll),
                        exp_sample(VECS[v].dl, VECS[v].rh, VECS[v].rl), 0);
        end

        // R8: empty buffer on both loads
        data_len = 2'b10;
        ckpol = 1'b0;
        clear_rx();
        enable = 1'b1;
        @(negedge clk);
        enable = 1'b0;
        wait_idle();
        check_frame("R8 empty", 32'h0, 32'h0, 2);

        // R8: a single buffered word is discarded at load
        write_word(16'hBEEF);
        clear_rx();
        enable = 1'b1;
        @(negedge clk);
        enable = 1'b0;
        write_word(16'h1357);
        write_word(16'h9BDF);
        wait_idle();
        check_frame("R8 partial", 32'h0, 32'h13579BDF, 1);

        // R7: write while full is ignored
        write_word(16'hCAFE);
        write_word(16'hF00D);
        @(negedge clk);
        check(word_req == 1'b0, "R7 req low when full", word_req, 0);
        raw_write(16'hDEAD);
        clear_rx();
        enable = 1'b1;
        @(negedge clk);
        enable = 1'b0;
        check(word_req == 1'b1, "R7 req after load", word_req, 1);
        write_word(16'h0246);
        write_word(16'h8ACE);
        wait_idle();
        check_frame("R7 full write", 32'hCAFEF00D, 32'h02468ACE, 0);

        // R6 edge discipline and bit period over the whole run
        check(bad_edge == 0, "R6 changes off falling edge", bad_edge, 0);
        check(bad_period == 0, "R6 bit period", bad_period, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule